// File: doc/BRIEF.md
# Hydraulic Valve Interlock Controller

This block commands two hydraulic solenoids, one for line pressure and one for forward flow, from operator push buttons, a pump-running indication and a panic input. Each valve has a request latch fed by an active-low "on" button and an active-low "off" button. A two-bit operating state is combined with the pump indication, both requests and panic to pick the next state. The valve drives and an invalid-operation lamp are decoded from that next state.

Every input passes through a multi-flop synchroniser. The controller only advances on a single-cycle evaluation strobe, so an external tick sets the response rate. On each strobe, the request latches are first updated from the buttons. The next state is then computed and, when allowed, overridden to idle by the pair of "off" buttons. The new valve drives are then written back into the request latches, so a request can never disagree with what the valve is doing. A heartbeat output flips on each strobe so that a supervisor can see the controller is alive.

The state is encoded as follows: idle 00, invalid operation 01, pressure only 10, pressure with flow 11. The outputs follow from the state: the pressure valve is on in 10 and 11, the flow valve is on only in 11, and the lamp is lit only in 01.

Top module: `valve_interlock`

## Requirements
- R1: Button inputs are active low, the pump input reads low when the pump runs, and panic is active high. Every input passes through SYNC_STAGES flops, so a level held for fewer than SYNC_STAGES strobed edges before a strobe is not seen by that strobe.
- R2: While rst_n is low and after it is released, all outputs are 0: both valves off, lamp off, heartbeat 0. The state is idle and both requests are clear.
- R3: Outputs change only on a clock edge where eval_en is 1. Input changes with eval_en low leave every output unchanged.
- R4: On a strobe with the pump not running, the controller goes to idle with all drives off, whatever its current state.
- R5: From idle with the pump running, a pressure request alone goes to state 10. Pressure with flow, or any request with panic, goes to state 01. No request, panic alone, or flow alone stays in idle.
- R6: In state 01, with the pump running and the override not applied, the controller stays in 01 with the lamp lit and both valves off, whatever the requests.
- R7: From state 10 with the pump running, the outcomes are:
  - pressure alone, or pressure with panic, stays in 10;
  - pressure with flow and no panic goes to 11;
  - no request and no panic goes to idle;
  - any other combination (flow without pressure, panic alone, or all three) goes to 01.
- R8: From state 11 with the pump running, the outcomes are:
  - pressure with flow and no panic stays in 11;
  - pressure in any other combination goes to 10;
  - no request and no panic goes to idle;
  - flow or panic without pressure goes to 01.
- R9: If the computed next state has its upper bit 0 and both "off" buttons are pressed, the state becomes idle with all drives off. An upper bit of 1 is not overridden.
- R10: When a valve's "on" and "off" buttons are pressed together, its request keeps its previous value.
- R11: After each strobe, each request equals its valve drive. A request that the transition did not act on is therefore discarded.
- R12: heartbeat inverts on every strobe and holds between strobes.
- R13: The flow valve is never on without the pressure valve, and the lamp is never lit while either valve is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_en | input | 1 | Single-cycle evaluation strobe |
| prs_on_n | input | 1 | Pressure "on" button, active low |
| prs_off_n | input | 1 | Pressure "off" button, active low |
| flw_on_n | input | 1 | Flow "on" button, active low |
| flw_off_n | input | 1 | Flow "off" button, active low |
| pump_n | input | 1 | Pump indication, low when running |
| panic | input | 1 | Panic input, active high |
| prs_valve | output | 1 | Pressure valve drive |
| flw_valve | output | 1 | Forward-flow valve drive |
| fault_led | output | 1 | Invalid-operation lamp |
| heartbeat | output | 1 | Toggles on each evaluation |

## Verification
Two things can happen on the same strobe: a transition into the invalid-operation state, and the two-button override back to idle. The bench provokes this from state 11 by pressing both "off" buttons while panic is high. The lookup alone would select state 01, but the override is required to win, so all drives and the lamp must read 0. The opposite case is also exercised: both "off" buttons are pressed while the pressure "on" button keeps the pressure request held, so the next state has its upper bit set and state 10 must survive.

// File: rtl/valve_interlock_pkg.sv
package valve_interlock_pkg;

   localparam int VI_STATE_W = 2;

   typedef enum logic [VI_STATE_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_FAULT = 2'b01,
      ST_PRESS = 2'b10,
      ST_BOTH  = 2'b11
   } vi_state_e;

   typedef struct packed {
      logic lamp;
      logic prs;
      logic flw;
   } vi_drive_t;

   // Drive pattern implied by a state
   function automatic vi_drive_t vi_decode(input vi_state_e st);
      vi_drive_t d;
      d.lamp = (st == ST_FAULT);
      d.prs  = (st == ST_PRESS) || (st == ST_BOTH);
      d.flw  = (st == ST_BOTH);
      return d;
   endfunction

endpackage

// File: rtl/vi_sync.sv
module vi_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 6,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("vi_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("vi_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe[0] <= RST_VAL;
      end else begin
         pipe[0] <= d;
      end
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe[s] <= RST_VAL;
            end else begin
               pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/vi_req_latch.sv
module vi_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_n,
   input  logic clr_n,
   input  logic upd,
   input  logic wb_val,
   output logic req
);

   logic held;

   // Buttons resolve against the held request; both pressed keeps it
   always_comb begin
      unique case ({set_n, clr_n})
         2'b01:   req = 1'b1;
         2'b10:   req = 1'b0;
         default: req = held;
      endcase
   end

   // After evaluation the request is replaced by the valve drive
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
      end else if (upd) begin
         held <= wb_val;
      end
   end

endmodule

// File: rtl/vi_next_state.sv
module vi_next_state
   import valve_interlock_pkg::*;
(
   input  vi_state_e cur,
   input  logic      pump_run,
   input  logic      prs_req,
   input  logic      flw_req,
   input  logic      panic,
   output vi_state_e nxt
);

   logic any_req;
   assign any_req = prs_req | flw_req;

   always_comb begin
      nxt = ST_IDLE;
      if (pump_run) begin
         unique case (cur)
            ST_IDLE: begin
               if (prs_req && !flw_req && !panic)
                  nxt = ST_PRESS;
               else if ((prs_req && flw_req) || (any_req && panic))
                  nxt = ST_FAULT;
               else
                  nxt = ST_IDLE;
            end
            ST_FAULT: nxt = ST_FAULT;
            ST_PRESS: begin
               if (prs_req && !flw_req)
                  nxt = ST_PRESS;
               else if (prs_req && flw_req && !panic)
                  nxt = ST_BOTH;
               else if (!any_req && !panic)
                  nxt = ST_IDLE;
               else
                  nxt = ST_FAULT;
            end
            ST_BOTH: begin
               if (prs_req && flw_req && !panic)
                  nxt = ST_BOTH;
               else if (prs_req)
                  nxt = ST_PRESS;
               else if (!flw_req && !panic)
                  nxt = ST_IDLE;
               else
                  nxt = ST_FAULT;
            end
            default: nxt = ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/valve_interlock.sv
module valve_interlock
   import valve_interlock_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eval_en,
   input  logic prs_on_n,
   input  logic prs_off_n,
   input  logic flw_on_n,
   input  logic flw_off_n,
   input  logic pump_n,
   input  logic panic,
   output logic prs_valve,
   output logic flw_valve,
   output logic fault_led,
   output logic heartbeat
);

   localparam int NUM_VALVES = 2;
   localparam int IN_W       = 2 * NUM_VALVES + 2;
   // Idle levels: buttons released, pump stopped, no panic
   localparam logic [IN_W-1:0] IN_IDLE = {1'b0, 1'b1, {(2*NUM_VALVES){1'b1}}};

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("valve_interlock: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [IN_W-1:0] raw_in, syn_in;
   assign raw_in = {panic, pump_n, flw_off_n, flw_on_n, prs_off_n, prs_on_n};

   vi_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (IN_W),
      .RST_VAL (IN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   logic pump_run_s, panic_s, both_off_s;
   assign pump_run_s = ~syn_in[2*NUM_VALVES];
   assign panic_s    = syn_in[2*NUM_VALVES+1];
   assign both_off_s = ~syn_in[1] & ~syn_in[3];

   vi_state_e state_q, state_lut, state_nxt;
   vi_drive_t drv_nxt;
   logic [NUM_VALVES-1:0] req, wb;

   assign wb = {drv_nxt.flw, drv_nxt.prs};

   // index 0: pressure, index 1: forward flow
   generate
      for (genvar v = 0; v < NUM_VALVES; v++) begin : g_req
         vi_req_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_n  (syn_in[2*v]),
            .clr_n  (syn_in[2*v+1]),
            .upd    (eval_en),
            .wb_val (wb[v]),
            .req    (req[v])
         );
      end
   endgenerate

   vi_next_state u_next (
      .cur      (state_q),
      .pump_run (pump_run_s),
      .prs_req  (req[0]),
      .flw_req  (req[1]),
      .panic    (panic_s),
      .nxt      (state_lut)
   );

   // Both off buttons clear any state whose upper bit is low
   always_comb begin
      state_nxt = state_lut;
      if (!state_lut[1] && both_off_s) begin
         state_nxt = ST_IDLE;
      end
      drv_nxt = vi_decode(state_nxt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         prs_valve <= 1'b0;
         flw_valve <= 1'b0;
         fault_led <= 1'b0;
         heartbeat <= 1'b0;
      end else if (eval_en) begin
         state_q   <= state_nxt;
         prs_valve <= drv_nxt.prs;
         flw_valve <= drv_nxt.flw;
         fault_led <= drv_nxt.lamp;
         heartbeat <= ~heartbeat;
      end
   end

endmodule

// File: rtl/vi_checker.sv
module vi_checker (
   input logic clk,
   input logic rst_n,
   input logic eval_en,
   input logic pump_run,
   input logic both_off,
   input logic prs_valve,
   input logic flw_valve,
   input logic fault_led,
   input logic heartbeat
);

   // R13
   flow_needs_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flw_valve |-> prs_valve);

   // R13
   lamp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_led |-> (!prs_valve && !flw_valve));

   // R4
   pump_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && !pump_run) |=> (!prs_valve && !flw_valve && !fault_led));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_en |=> ($stable(prs_valve) && $stable(flw_valve) && $stable(fault_led) && $stable(heartbeat)));

   // R12
   beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eval_en |=> (heartbeat != $past(heartbeat)));

   // R6
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && fault_led && pump_run && !both_off) |=> fault_led);

   // R9
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && fault_led && both_off) |=> (!fault_led && !prs_valve && !flw_valve));

endmodule

bind valve_interlock vi_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eval_en   (eval_en),
   .pump_run  (pump_run_s),
   .both_off  (both_off_s),
   .prs_valve (prs_valve),
   .flw_valve (flw_valve),
   .fault_led (fault_led),
   .heartbeat (heartbeat)
);

// File: tb/valve_interlock_tb.sv
`timescale 1ns/100ps
module valve_interlock_tb;

   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eval_en = 1'b0;
   logic prs_on_n = 1'b1, prs_off_n = 1'b1, flw_on_n = 1'b1, flw_off_n = 1'b1;
   logic pump_n = 1'b1, panic = 1'b0;
   logic prs_valve, flw_valve, fault_led, heartbeat;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic hb_exp = 1'b0;

   always #2.5 clk = ~clk;

   valve_interlock #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .eval_en(eval_en),
      .prs_on_n(prs_on_n), .prs_off_n(prs_off_n),
      .flw_on_n(flw_on_n), .flw_off_n(flw_off_n),
      .pump_n(pump_n), .panic(panic),
      .prs_valve(prs_valve), .flw_valve(flw_valve),
      .fault_led(fault_led), .heartbeat(heartbeat)
   );

   // {pon_n, poff_n, fon_n, foff_n, pump_n, panic, exp_prs, exp_flw, exp_lamp}
   localparam logic [8:0] VEC [47] = '{
      9'b1111_1_0_000, // R4 pump stopped
      9'b1111_0_0_000, // R5 idle, no request
      9'b1101_0_0_000, // R5 flow alone stays idle
      9'b1111_0_0_000, // R11 discarded flow request
      9'b0111_0_0_100, // R5 pressure alone
      9'b1111_0_0_100, // R7 held request
      9'b1111_0_1_100, // R7 pressure with panic
      9'b1101_0_0_110, // R7 to both
      9'b1111_0_0_110, // R8 stay both
      9'b1110_0_0_100, // R8 pressure alone
      9'b1101_0_0_110, // R7
      9'b1111_0_1_100, // R8 all three
      9'b1101_0_0_110, // R7
      9'b1011_0_0_001, // R8 flow alone
      9'b1111_0_0_001, // R6
      9'b0111_0_0_001, // R6 request ignored
      9'b1010_0_0_000, // R9 override
      9'b0111_0_0_100, // R5
      9'b0011_0_0_100, // R10 both pressure buttons
      9'b1011_0_0_000, // R7 no request
      9'b0101_0_0_001, // R5 pressure with flow
      9'b1111_1_0_000, // R4 leaves fault
      9'b0111_0_0_100, // R5
      9'b1100_0_0_100, // R10 both flow buttons
      9'b1111_1_0_000, // R4 from pressure
      9'b1111_0_1_000, // R5 panic alone
      9'b0111_0_1_001, // R5 request with panic
      9'b1010_0_0_000, // R9
      9'b0111_0_0_100, // R5
      9'b1101_0_0_110, // R7
      9'b1010_0_0_000, // R8 no request
      9'b0111_0_0_100, // R5
      9'b1101_0_1_001, // R7 all three
      9'b1111_1_0_000, // R4
      9'b0111_0_0_100, // R5
      9'b1011_0_1_001, // R7 panic alone
      9'b1010_0_0_000, // R9
      9'b0111_0_0_100, // R5
      9'b1101_0_0_110, // R7
      9'b1010_0_1_000, // R9 override beats fault entry
      9'b1111_0_0_000, // R9 stays idle
      9'b0111_0_0_100, // R5
      9'b1001_0_0_001, // R7 flow without pressure
      9'b1111_1_0_000, // R4
      9'b0111_0_0_100, // R5
      9'b0010_0_0_100, // R9 upper bit set, no override
      9'b1111_1_0_000  // R4
   };

   task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: {prs,flw,lamp,hb} got=%b exp=%b", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [8:0] v);
      @(negedge clk);
      {prs_on_n, prs_off_n, flw_on_n, flw_off_n, pump_n, panic} = v[8:3];
      repeat (SYNC + 1) @(negedge clk);
   endtask

   task automatic strobe();
      eval_en = 1'b1;
      @(negedge clk);
      eval_en = 1'b0;
      hb_exp = ~hb_exp;
   endtask

   initial begin
      #(20000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 outputs in reset
      check("R2 in reset", {prs_valve, flw_valve, fault_led, heartbeat}, 4'b0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R2 after release", {prs_valve, flw_valve, fault_led, heartbeat}, 4'b0000);

      for (int i = 0; i < 47; i++) begin
         drive(VEC[i]);
         strobe();
         check($sformatf("R4/R5/R6/R7/R8/R9/R10/R11/R12 vector %0d", i),
               {prs_valve, flw_valve, fault_led, heartbeat}, {VEC[i][2:0], hb_exp});
      end

      // R3: request to pressure with no strobe leaves outputs alone
      drive(9'b0111_0_0_000);
      repeat (10) @(negedge clk);
      check("R3 no strobe", {prs_valve, flw_valve, fault_led, heartbeat}, {3'b000, hb_exp});
      prs_on_n = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      strobe();
      check("R3 pulse missed while idle", {prs_valve, flw_valve, fault_led, heartbeat}, {3'b000, hb_exp});

      // R1: a press only SYNC cycles old is not seen by the strobes
      prs_on_n = 1'b0;
      eval_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      eval_en = 1'b0;
      prs_on_n = 1'b1;
      hb_exp = ~hb_exp;
      hb_exp = ~hb_exp;
      check("R1 sync latency", {prs_valve, flw_valve, fault_led, heartbeat}, {3'b000, hb_exp});
      repeat (SYNC + 1) @(negedge clk);
      strobe();
      check("R1 late press ignored", {prs_valve, flw_valve, fault_led, heartbeat}, {3'b000, hb_exp});

      // R1 pump polarity: high pump_n means stopped, request has no effect
      drive(9'b0111_1_0_000);
      strobe();
      check("R1 pump high is stopped", {prs_valve, flw_valve, fault_led, heartbeat}, {3'b000, hb_exp});
      drive(9'b0111_0_0_100);
      strobe();
      check("R1 pump low is running", {prs_valve, flw_valve, fault_led, heartbeat}, {3'b100, hb_exp});

      // R2 reset mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R2 reset from pressure", {prs_valve, flw_valve, fault_led, heartbeat}, 4'b0000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule